// File: doc/BRIEF.md
# Nibble-Register Cartridge Bank Controller

This block selects the ROM bank of a cartridge. Software reaches it through a small indirect register window in the CPU address range 0xA000–0xBFFF. An odd-address write either arms the controller with a fixed key or, once the controller is armed, loads a register-select byte. An even-address write deposits four data bits into one half of the register that the select byte names.

Each register is built from two separate nibble writes. When the high half of an implemented register is written, the register value is committed and the controller disarms itself. Writing the high half of register 0 drives the five-bit ROM bank output from the combined byte.

A read from the window returns a status byte. Bit 0 of that byte shows whether the controller is armed.

Top module: `nrb_bank_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the armed flag, the select latch and every register, and drives `rom_bank` to 0.
- R2: A write whose address bits [15:13] are not 3'b101 changes neither the armed flag, the select latch, any register nor `rom_bank`.
- R3: While disarmed, an odd-address window write of 0x0A sets the armed flag. Any other value leaves the controller disarmed and does not load the select latch.
- R4: While armed, an odd-address window write loads the whole data byte into the select latch. Latch bits [7:1] are the register index, and latch bit 0 picks the half (0 is low nibble [3:0], 1 is high nibble [7:4]).
- R5: An even-address window write puts data bits [3:0] into the selected half of the indexed register and leaves the other half unchanged. Data bits [7:4] are ignored.
- R6: Even-address window writes take effect whether the controller is armed or not, and they use the current select latch.
- R7: An even-address window write to the high half of an implemented register (index 0) clears the armed flag.
- R8: A high-half write to register 0 sets `rom_bank` to bits [4:0] of the combined byte, which is the new high nibble over the stored low nibble, on the next clock edge. A low-half write alone leaves `rom_bank` unchanged.
- R9: An even-address window write whose register index is 1 or more changes no state. It neither disarms the controller nor moves `rom_bank`.
- R10: `cpu_rdata` is combinational. With `cpu_rd` high at an odd window address it is 0xFF. At an even window address it is 0xF0 with bit 0 equal to the armed flag. Otherwise it is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one access per cycle |
| cpu_rd | input | 1 | Read strobe |
| cpu_rdata | output | 8 | Status byte read data |
| rom_bank | output | 5 | Selected ROM bank |

## Verification
The bound checker watches several behaviours on every cycle. It checks the key handshake in both directions, latch loading while armed, disarming after a high-half commit, window filtering of stray writes, and the read-status encoding. It also checks that `rom_bank` never moves except one cycle after a high-half write to register 0. Other behaviours depend on a history of several writes, so only the bench scenarios can show them. These are the byte assembled from two nibbles written at different times, high data bits being dropped, writes to unimplemented indices leaving state untouched, and a latch value surviving a disarm so that a later even write while disarmed still reaches the bank.

// File: rtl/nrb_pkg.sv
`timescale 1ns/1ps
package nrb_pkg;

   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } nrb_half_e;

   typedef struct packed {
      logic wr_odd;
      logic wr_even;
      logic rd_odd;
      logic rd_even;
   } nrb_strobe_t;

endpackage

// File: rtl/nrb_addr_decode.sv
`timescale 1ns/1ps
module nrb_addr_decode #(
   parameter int ADDR_W = 16,
   parameter int TAG_W  = 3,
   parameter logic [TAG_W-1:0] WINDOW_TAG = 3'b101
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output nrb_pkg::nrb_strobe_t strb
);
   logic hit;
   logic odd;

   assign hit = (addr[ADDR_W-1 -: TAG_W] == WINDOW_TAG);
   assign odd = addr[0];

   logic unused_mid;
   assign unused_mid = ^addr[ADDR_W-TAG_W-1:1];

   always_comb begin
      strb.wr_odd  = hit &  odd & wr;
      strb.wr_even = hit & ~odd & wr;
      strb.rd_odd  = hit &  odd & rd;
      strb.rd_even = hit & ~odd & rd;
   end
endmodule

// File: rtl/nrb_lock_ctrl.sv
`timescale 1ns/1ps
module nrb_lock_ctrl #(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] KEY = 8'h0A
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_odd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              relock,
   output logic              armed,
   output logic [DATA_W-1:0] sel
);
   always_ff @(posedge clk) begin
      if (rst) begin
         armed <= 1'b0;
         sel   <= '0;
      end else if (wr_odd) begin
         if (armed) begin
            sel <= wdata;
         end else if (wdata == KEY) begin
            armed <= 1'b1;
         end
      end else if (relock) begin
         armed <= 1'b0;
      end
   end
endmodule

// File: rtl/nrb_nibble_regs.sv
`timescale 1ns/1ps
module nrb_nibble_regs #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 1,
   parameter int BANK_W   = 5,
   parameter int BANK_IDX = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_even,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] sel,
   output logic              relock,
   output logic [BANK_W-1:0] bank
);
   import nrb_pkg::*;

   localparam int NIB_W = DATA_W / 2;
   localparam int IDX_W = DATA_W - 1;

   logic [IDX_W-1:0] idx;
   nrb_half_e        half;
   logic [NIB_W-1:0] nib;
   logic             idx_valid;
   logic [DATA_W-1:0] reg_vals [NUM_REGS];

   assign idx       = sel[DATA_W-1:1];
   assign half      = nrb_half_e'(sel[0]);
   assign nib       = wdata[NIB_W-1:0];
   assign idx_valid = (int'(idx) < NUM_REGS);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [DATA_W-1:0] r_q;
      logic              hit;
      assign hit = wr_even && (int'(idx) == g);
      always_ff @(posedge clk) begin
         if (rst) begin
            r_q <= '0;
         end else if (hit) begin
            if (half == HALF_HI) r_q[DATA_W-1:NIB_W] <= nib;
            else                 r_q[NIB_W-1:0]      <= nib;
         end
      end
      assign reg_vals[g] = r_q;
   end

   logic [DATA_W-1:0] merged;
   assign merged = {nib, reg_vals[BANK_IDX][NIB_W-1:0]};

   always_ff @(posedge clk) begin
      if (rst) begin
         bank <= '0;
      end else if (wr_even && half == HALF_HI && int'(idx) == BANK_IDX) begin
         bank <= merged[BANK_W-1:0];
      end
   end

   assign relock = wr_even && (half == HALF_HI) && idx_valid;

   logic unused_bits;
   assign unused_bits = ^{wdata[DATA_W-1:NIB_W], merged, reg_vals[BANK_IDX][DATA_W-1:NIB_W]};
endmodule

// File: rtl/nrb_bank_ctrl.sv
`timescale 1ns/1ps
module nrb_bank_ctrl #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int BANK_W   = 5,
   parameter int NUM_REGS = 1,
   parameter int BANK_IDX = 0,
   parameter int TAG_W    = 3,
   parameter logic [TAG_W-1:0]  WINDOW_TAG = 3'b101,
   parameter logic [DATA_W-1:0] KEY        = 8'h0A
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [BANK_W-1:0] rom_bank
);
   localparam int NIB_W = DATA_W / 2;

   if (DATA_W % 2 != 0) begin : g_bad_data
      $error("DATA_W must be even");
   end
   if (BANK_W > DATA_W) begin : g_bad_bank
      $error("BANK_W must not exceed DATA_W");
   end
   if (NUM_REGS < 1 || NUM_REGS > (1 << (DATA_W - 1))) begin : g_bad_regs
      $error("NUM_REGS out of range");
   end
   if (BANK_IDX >= NUM_REGS) begin : g_bad_idx
      $error("BANK_IDX must name an implemented register");
   end
   if (TAG_W >= ADDR_W) begin : g_bad_tag
      $error("TAG_W must be smaller than ADDR_W");
   end

   nrb_pkg::nrb_strobe_t strb;
   logic                 unlocked_q;
   logic [DATA_W-1:0]    sel_q;
   logic                 relock;

   nrb_addr_decode #(
      .ADDR_W(ADDR_W), .TAG_W(TAG_W), .WINDOW_TAG(WINDOW_TAG)
   ) u_dec (
      .addr(cpu_addr), .wr(cpu_wr), .rd(cpu_rd), .strb(strb)
   );

   nrb_lock_ctrl #(.DATA_W(DATA_W), .KEY(KEY)) u_lock (
      .clk(clk), .rst(rst), .wr_odd(strb.wr_odd), .wdata(cpu_wdata),
      .relock(relock), .armed(unlocked_q), .sel(sel_q)
   );

   nrb_nibble_regs #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BANK_W(BANK_W), .BANK_IDX(BANK_IDX)
   ) u_regs (
      .clk(clk), .rst(rst), .wr_even(strb.wr_even), .wdata(cpu_wdata),
      .sel(sel_q), .relock(relock), .bank(rom_bank)
   );

   always_comb begin
      cpu_rdata = '0;
      if (strb.rd_odd) begin
         cpu_rdata = '1;
      end else if (strb.rd_even) begin
         cpu_rdata = {{NIB_W{1'b1}}, {(NIB_W-1){1'b0}}, unlocked_q};
      end
   end
endmodule

// File: rtl/nrb_bank_ctrl_chk.sv
`timescale 1ns/1ps
module nrb_bank_ctrl_chk #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int BANK_W   = 5,
   parameter int NUM_REGS = 1,
   parameter int BANK_IDX = 0,
   parameter int TAG_W    = 3,
   parameter logic [TAG_W-1:0]  WINDOW_TAG = 3'b101,
   parameter logic [DATA_W-1:0] KEY        = 8'h0A
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic              cpu_wr,
   input logic              cpu_rd,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic [BANK_W-1:0] rom_bank,
   input logic              unlocked_q,
   input logic [DATA_W-1:0] sel_q
);
   logic in_win;
   assign in_win = (cpu_addr[ADDR_W-1 -: TAG_W] == WINDOW_TAG);

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (rom_bank == '0 && !unlocked_q && sel_q == '0));

   // R2
   window_filter_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_wr && !in_win) |=> ($stable(rom_bank) && $stable(unlocked_q) && $stable(sel_q)));

   // R3
   wrong_key_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_wr && in_win && cpu_addr[0] && !unlocked_q && cpu_wdata != KEY)
      |=> (!unlocked_q && $stable(sel_q)));

   // R3
   right_key_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_wr && in_win && cpu_addr[0] && !unlocked_q && cpu_wdata == KEY) |=> unlocked_q);

   // R4
   sel_load_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_wr && in_win && cpu_addr[0] && unlocked_q) |=> (sel_q == $past(cpu_wdata)));

   // R7
   relock_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_wr && in_win && !cpu_addr[0] && sel_q[0] && int'(sel_q[DATA_W-1:1]) < NUM_REGS)
      |=> !unlocked_q);

   // R8
   bank_source_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(rom_bank) |->
      $past(cpu_wr && in_win && !cpu_addr[0] && sel_q[0] && int'(sel_q[DATA_W-1:1]) == BANK_IDX));

   // R10
   rd_odd_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_rd && in_win && cpu_addr[0]) |-> (cpu_rdata == '1));

   // R10
   rd_even_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_rd && in_win && !cpu_addr[0]) |->
      (cpu_rdata[DATA_W-1:DATA_W/2] == '1 && cpu_rdata[0] == unlocked_q));
endmodule

bind nrb_bank_ctrl nrb_bank_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .NUM_REGS(NUM_REGS),
   .BANK_IDX(BANK_IDX), .TAG_W(TAG_W), .WINDOW_TAG(WINDOW_TAG), .KEY(KEY)
) u_chk (
   .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
   .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .rom_bank(rom_bank),
   .unlocked_q(unlocked_q), .sel_q(sel_q)
);

// File: tb/nrb_bank_ctrl_test.sv
`timescale 1ns/1ps
module nrb_bank_ctrl_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_wr = 1'b0;
   logic        cpu_rd = 1'b0;
   logic [7:0]  cpu_rdata;
   logic [4:0]  rom_bank;

   int total = 0;
   int fails = 0;
   bit done  = 0;

   typedef struct {
      logic [4:0] bank;
      logic [7:0] rdata;
      string      tag;
   } item_t;

   item_t sb_q[$];

   always #10 clk = ~clk;

   nrb_bank_ctrl uut (
      .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .rom_bank(rom_bank)
   );

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic expect_rd(input logic [15:0] a, input logic en,
                            input logic [4:0] eb, input logic [7:0] ed, input string tag);
      item_t it;
      @(negedge clk);
      cpu_addr = a; cpu_rd = en; cpu_wr = 1'b0;
      it.bank = eb; it.rdata = ed; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   initial begin : monitor
      item_t it;
      forever begin
         @(posedge clk);
         #5;
         if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            total++;
            if (rom_bank !== it.bank || cpu_rdata !== it.rdata) begin
               fails++;
               $display("FAIL %s: bank=%h rdata=%h expected bank=%h rdata=%h",
                        it.tag, rom_bank, cpu_rdata, it.bank, it.rdata);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: run still active (actual hung, expected finished)");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst = 1'b0;
      expect_rd(16'hA000, 1, 5'h00, 8'hF0, "R1 reset state");
      expect_rd(16'hA001, 1, 5'h00, 8'hFF, "R10 odd read");
      expect_rd(16'hA000, 0, 5'h00, 8'h00, "R10 no strobe");
      wr(16'hA000, 8'h05);
      expect_rd(16'hA000, 1, 5'h00, 8'hF0, "R8 low half only, R6 locked write");
      wr(16'h8001, 8'h0A);
      expect_rd(16'hA000, 1, 5'h00, 8'hF0, "R2 key outside window");
      expect_rd(16'h8000, 1, 5'h00, 8'h00, "R10 read outside window");
      wr(16'hA001, 8'h05);
      expect_rd(16'hA000, 1, 5'h00, 8'hF0, "R3 wrong key");
      wr(16'hA001, 8'h0A);
      expect_rd(16'hA000, 1, 5'h00, 8'hF1, "R3 key unlocks");
      wr(16'hA001, 8'h01);
      expect_rd(16'hA001, 1, 5'h00, 8'hFF, "R10 odd read armed");
      wr(16'hC000, 8'h03);
      expect_rd(16'hA000, 1, 5'h00, 8'hF1, "R2 even write outside window");
      wr(16'hA000, 8'hE1);
      expect_rd(16'hA000, 1, 5'h15, 8'hF0, "R4 R5 R7 R8 high commit");
      wr(16'hA001, 8'h0A);
      wr(16'hA001, 8'h00);
      wr(16'hA000, 8'h9C);
      expect_rd(16'hA000, 1, 5'h15, 8'hF1, "R5 low nibble, R8 no bank move");
      wr(16'hA001, 8'h03);
      wr(16'hA000, 8'h07);
      expect_rd(16'hA000, 1, 5'h15, 8'hF1, "R9 index1 high");
      wr(16'hA001, 8'h02);
      wr(16'hA000, 8'h04);
      expect_rd(16'hA000, 1, 5'h15, 8'hF1, "R9 index1 low");
      wr(16'hA001, 8'h01);
      wr(16'hA000, 8'h0F);
      expect_rd(16'hA000, 1, 5'h1C, 8'hF0, "R8 bank bits 4:0");
      wr(16'hA000, 8'h02);
      expect_rd(16'hA000, 1, 5'h0C, 8'hF0, "R6 write while locked");
      wr(16'hA001, 8'h00);
      wr(16'hA000, 8'h03);
      expect_rd(16'hA000, 1, 5'h1C, 8'hF0, "R3 locked odd write keeps latch");
      repeat (3) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule